// File: doc/BRIEF.md
# Carry-Select Adder with All-Ones Carry Detection

This block adds two unsigned operands of a parameterised width together with a single carry-in bit. It returns the sum and a carry-out. The datapath is a chain of 4-bit slices. The lowest slice is an ordinary ripple-carry adder that is fed directly by the external carry-in.

Every higher slice holds only one ripple chain, and that chain always assumes a carry-in of zero. The result for an incoming carry of one is taken from that zero-carry sum by an increment transform. The transform flips bits from the least significant end upward, up to and including the first zero, and leaves the bits above unchanged. The carry arriving from the slice below picks which of the two sums is used.

The slice carry-out needs no second chain. A detector ANDs together the XOR of each operand bit pair. When every position propagates and the incoming carry is one, the slice carry is forced high. In all other cases the slice carry is the carry of the zero-carry chain. Integrators use the block as a drop-in wide adder. Its width must be a multiple of four.

Top module: `csa_adder`

## Requirements
- R1: For every input combination, {carryOut, sumOut} equals opA + opB + carryIn, computed as unsigned WIDTH+1-bit arithmetic.
- R2: The lowest 4-bit slice (sumOut[3:0]) adds opA[3:0], opB[3:0] and carryIn directly. For example, opA=5, opB=9, carryIn=1 gives sumOut=0x000F and carryOut=0.
- R3: When a slice above the lowest receives a carry of one, its sum is its zero-carry sum plus one modulo 16. For example, opA=0x007F, opB=0x0001, carryIn=0 gives 0x0080.
- R4: When all four bit pairs of a slice differ (opA^opB = 0xF in that slice) and the slice's incoming carry is one, the slice carry-out is 1 even though its zero-carry chain produces no carry. For example, opA=0x00F8, opB=0x0008 gives 0x0100.
- R5: When every operand bit pair differs and carryIn=1, the carry travels through every slice, so sumOut=0 and carryOut=1.
- R6: When every operand bit pair differs and carryIn=0, sumOut is all ones and carryOut=0.
- R7: With both operands zero, sumOut equals carryIn in bit 0 and is zero elsewhere, and carryOut=0.
- R8: With both operands all ones, carryOut=1 and sumOut equals all ones with bit 0 equal to carryIn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | WIDTH | First addend |
| opB | input | WIDTH | Second addend |
| carryIn | input | 1 | Carry into the lowest slice |
| sumOut | output | WIDTH | Sum bits |
| carryOut | output | 1 | Carry out of the highest slice |

## Verification
The checker tests the full arithmetic identity on every evaluation. It also tests the three fixed-point patterns: all positions propagating, zero operands and all-ones operands. Slice-level behaviour can only be observed at the ports through chosen operand patterns, so the bench supplies those scenarios. These are the increment path of a single slice, a slice that passes a carry by propagation alone, and the lowest slice acting alone. A large seeded random set covers mixed generate and propagate patterns across all slice boundaries.

// File: rtl/csa_pkg.sv
`timescale 1ns/1ps
package csa_pkg;
  localparam int BLK_W = 4;

  typedef struct packed {
    logic takeInc;
    logic forceCarry;
  } blkSel_t;
endpackage

// File: rtl/csa_ripple.sv
`timescale 1ns/1ps
module csa_ripple #(
  parameter int W = csa_pkg::BLK_W
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic         carryIn,
  output logic [W-1:0] sumOut,
  output logic         carryOut
);
  logic [W:0] chain;

  assign chain[0] = carryIn;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_fa
      assign sumOut[i]  = opA[i] ^ opB[i] ^ chain[i];
      assign chain[i+1] = (opA[i] & opB[i]) | (chain[i] & (opA[i] ^ opB[i]));
    end
  endgenerate

  assign carryOut = chain[W];
endmodule

// File: rtl/csa_add_one.sv
`timescale 1ns/1ps
module csa_add_one #(
  parameter int W = csa_pkg::BLK_W
) (
  input  logic [W-1:0] baseSum,
  output logic [W-1:0] incSum
);
  // A bit flips while every lower bit is one; the first zero flips and stops the run.
  logic [W:0] allLowOnes;

  assign allLowOnes[0] = 1'b1;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_inc
      assign incSum[i]       = baseSum[i] ^ allLowOnes[i];
      assign allLowOnes[i+1] = allLowOnes[i] & baseSum[i];
    end
  endgenerate
endmodule

// File: rtl/csa_sel_ctrl.sv
`timescale 1ns/1ps
module csa_sel_ctrl #(
  parameter int W = csa_pkg::BLK_W
) (
  input  logic [W-1:0]      opA,
  input  logic [W-1:0]      opB,
  input  logic              blkCarryIn,
  output csa_pkg::blkSel_t  sel
);
  logic allProp;

  // Zero-carry sum is all ones exactly when every position propagates.
  assign allProp        = &(opA ^ opB);
  assign sel.takeInc    = blkCarryIn;
  assign sel.forceCarry = allProp & blkCarryIn;
endmodule

// File: rtl/csa_sel_block.sv
`timescale 1ns/1ps
module csa_sel_block #(
  parameter int W = csa_pkg::BLK_W
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic         blkCarryIn,
  output logic [W-1:0] sumOut,
  output logic         carryOut
);
  logic [W-1:0]     sumZero;
  logic [W-1:0]     sumInc;
  logic             carryZero;
  csa_pkg::blkSel_t sel;

  csa_ripple #(.W(W)) u_rca (
    .opA(opA), .opB(opB), .carryIn(1'b0),
    .sumOut(sumZero), .carryOut(carryZero)
  );

  csa_add_one #(.W(W)) u_inc (
    .baseSum(sumZero), .incSum(sumInc)
  );

  csa_sel_ctrl #(.W(W)) u_ctrl (
    .opA(opA), .opB(opB), .blkCarryIn(blkCarryIn), .sel(sel)
  );

  assign sumOut   = sel.takeInc ? sumInc : sumZero;
  assign carryOut = carryZero | sel.forceCarry;
endmodule

// File: rtl/csa_adder.sv
`timescale 1ns/1ps
module csa_adder #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sumOut,
  output logic             carryOut
);
  localparam int BW   = csa_pkg::BLK_W;
  localparam int NBLK = WIDTH / BW;

  generate
    if (WIDTH % BW != 0 || WIDTH < BW) begin : g_bad_width
      $error("csa_adder: WIDTH must be a positive multiple of the slice width");
    end
  endgenerate

  logic [NBLK:0] blkCarry;

  assign blkCarry[0] = carryIn;

  genvar b;
  generate
    for (b = 0; b < NBLK; b++) begin : g_blk
      if (b == 0) begin : g_first
        csa_ripple #(.W(BW)) u_first (
          .opA(opA[BW-1:0]), .opB(opB[BW-1:0]), .carryIn(blkCarry[0]),
          .sumOut(sumOut[BW-1:0]), .carryOut(blkCarry[1])
        );
      end else begin : g_sel
        csa_sel_block #(.W(BW)) u_sel (
          .opA(opA[b*BW +: BW]), .opB(opB[b*BW +: BW]),
          .blkCarryIn(blkCarry[b]),
          .sumOut(sumOut[b*BW +: BW]), .carryOut(blkCarry[b+1])
        );
      end
    end
  endgenerate

  assign carryOut = blkCarry[NBLK];
endmodule

// File: rtl/csa_adder_chk.sv
`timescale 1ns/1ps
module csa_adder_chk #(
  parameter int WIDTH = 16
) (
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic             carryIn,
  input logic [WIDTH-1:0] sumOut,
  input logic             carryOut
);
  logic [WIDTH:0] refSum;
  logic [WIDTH-1:0] onesW;

  assign onesW  = '1;
  assign refSum = {1'b0, opA} + {1'b0, opB} + {{WIDTH{1'b0}}, carryIn};

  always_comb begin
    a_r1_sum_matches: assert ({carryOut, sumOut} == refSum)
      else $error("R1 sum mismatch");
    if ((opA ^ opB) == onesW && carryIn)
      a_r5_full_ripple: assert (sumOut == '0 && carryOut)
        else $error("R5 full ripple");
    if ((opA ^ opB) == onesW && !carryIn)
      a_r6_all_prop_no_carry: assert (sumOut == onesW && !carryOut)
        else $error("R6 propagate without carry");
    if (opA == '0 && opB == '0)
      a_r7_zero_operands: assert (sumOut == {{(WIDTH-1){1'b0}}, carryIn} && !carryOut)
        else $error("R7 zero operands");
    if (opA == onesW && opB == onesW)
      a_r8_max_operands: assert (carryOut && sumOut == {onesW[WIDTH-1:1], carryIn})
        else $error("R8 max operands");
  end
endmodule

bind csa_adder csa_adder_chk #(.WIDTH(WIDTH)) u_chk (
  .opA(opA), .opB(opB), .carryIn(carryIn), .sumOut(sumOut), .carryOut(carryOut)
);

// File: tb/sim_csa_adder.sv
`timescale 1ns/1ps
module sim_csa_adder;
  localparam int W = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [W-1:0] opA = '0, opB = '0, sumOut;
  logic         carryIn = 1'b0, carryOut;
  int checks = 0, errors = 0;
  bit done = 0;

  csa_adder #(.WIDTH(W)) u0 (
    .opA(opA), .opB(opB), .carryIn(carryIn), .sumOut(sumOut), .carryOut(carryOut)
  );

  function automatic logic [W:0] golden(input logic [W-1:0] a, input logic [W-1:0] b,
                                        input logic c);
    return {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
  endfunction

  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic c,
                       input string req);
    logic [W:0] exp;
    @(negedge clk);
    opA = a; opB = b; carryIn = c;
    #1;
    exp = golden(a, b, c);
    checks++;
    if ({carryOut, sumOut} !== exp) begin
      errors++;
      $display("FAIL %s: a=%h b=%h cin=%0d got %h expected %h", req, a, b, c,
               {carryOut, sumOut}, exp);
    end
  endtask

  initial begin
    // R7: reset-like idle state with zero operands
    apply('0, '0, 1'b0, "R7");
    apply('0, '0, 1'b1, "R7");
    // R2: lowest slice alone
    apply(16'h0005, 16'h0009, 1'b1, "R2");
    apply(16'h0007, 16'h0008, 1'b0, "R2");
    // R3: increment path of a higher slice
    apply(16'h007F, 16'h0001, 1'b0, "R3");
    apply(16'h0F00, 16'h00FF, 1'b1, "R3");
    // R4: slice passes a carry by propagation alone
    apply(16'h00F8, 16'h0008, 1'b0, "R4");
    apply(16'h0A5F, 16'h05A0, 1'b1, "R4");
    // R5 / R6: every position propagates
    apply(16'hFFFF, 16'h0000, 1'b1, "R5");
    apply(16'h5A5A, 16'hA5A5, 1'b1, "R5");
    apply(16'hFFFF, 16'h0000, 1'b0, "R6");
    apply(16'h3C3C, 16'hC3C3, 1'b0, "R6");
    // R8: maximum operands
    apply(16'hFFFF, 16'hFFFF, 1'b0, "R8");
    apply(16'hFFFF, 16'hFFFF, 1'b1, "R8");
    // R1: seeded random patterns
    void'($urandom(32'd1234));
    for (int n = 0; n < 3000; n++)
      apply(W'($urandom), W'($urandom), 1'($urandom), "R1");
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, got timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule